// File: doc/BRIEF.md
# Serial Seven-Segment Digit Write Port

This block is the serial input stage of a ten-digit seven-segment display controller. A frame of ten bits arrives one bit at a time. A bit is taken on each clock edge where the shift enable is high. The frame carries two annunciator flags, a four-bit binary code and a four-bit digit address. The block raises an acceptance flag once a complete frame with a legal address is held.

A synchronous active-low write strobe then acts on the held frame. If the frame is accepted, the strobe stores the code and annunciators into the addressed digit entry and emits a one-cycle write pulse carrying the stored fields. If the frame is not accepted, nothing is stored. In both cases the strobe clears the shift register and the bit counter.

The digit store is kept inside the block and is visible as a flat vector for the display drive logic. Segment decoding and the drive waveforms are handled elsewhere.

Top module: `serial_digit_writer`

## Requirements
- R1: A synchronous reset (`rst` high) clears every digit entry to 0 (code 0, both annunciators off), drives `accepted` low and drives `we_o` low.
- R2: A bit on `ser_data` is shifted in on each rising `clk` edge where `shift_en` is high and `wr_n` is high. The serial order is annunciator 1, annunciator 2, code bit 0 up to code bit 3, then address bit 0 up to address bit 3. Each digit entry `i` occupies `digits_o[6*i+5:6*i]`, laid out as {code[3:0], ann2, ann1}.
- R3: `accepted` is high in the cycle after exactly ten bits have been shifted since the last reset or write, provided the address is 0 to 9. Addresses 0 and 9 are both legal.
- R4: With ten bits held and an address from 10 to 15, `accepted` stays low.
- R5: An eleventh shifted bit drives `accepted` low. It stays low for any further bits until a write or a reset.
- R6: A cycle with `wr_n` low while `accepted` is high has two effects at the next edge. It writes {code, ann2, ann1} into the addressed entry. It also gives a one-cycle `we_o` pulse with `addr_o`, `code_o` and `ann_o` (ann_o = {ann2, ann1}) equal to the frame. All other entries are left unchanged.
- R7: A cycle with `wr_n` low while `accepted` is low stores nothing, leaves every digit entry unchanged and keeps `we_o` low.
- R8: Any write cycle clears the shift logic. `accepted` is low afterwards, and bits shifted before the write do not count toward the next frame.
- R9: When `wr_n` is low and `shift_en` is high in the same cycle, the write takes effect and the data bit of that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Takes `ser_data` on this clock edge |
| ser_data | input | 1 | Serial frame data |
| wr_n | input | 1 | Synchronous write strobe, active low |
| accepted | output | 1 | A complete frame with a legal address is held |
| we_o | output | 1 | One-cycle pulse when a digit is written |
| addr_o | output | 4 | Digit written |
| code_o | output | 4 | Code written |
| ann_o | output | 2 | Annunciators written, {ann2, ann1} |
| digits_o | output | 60 | Digit store, entry i at [6i+5:6i] |

## Verification
The write strobe and a shift request can fall in the same cycle. The block must let the write win and drop that cycle's data bit. The bench sets up this collision in two cases: on an accepted frame, and on a frame that is partly shifted in. It then sends a fresh ten-bit frame. If the dropped bit leaked into the shift register, the count and the stored fields would both be off by one, and the bench judges the result by comparing the acceptance flag and the stored digit against its own frame model.

// File: rtl/serial_digit_writer.sv
module serial_digit_writer #(
  parameter int DIGITS = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic                  ser_data,
  input  logic                  wr_n,
  output logic                  accepted,
  output logic                  we_o,
  output logic [3:0]            addr_o,
  output logic [3:0]            code_o,
  output logic [1:0]            ann_o,
  output logic [DIGITS*6-1:0]   digits_o
);
  localparam int          FRAME = 10;
  localparam logic [3:0]  FULL  = 4'(FRAME);
  localparam logic [3:0]  OVER  = 4'(FRAME + 1);
  localparam logic [3:0]  LAST  = 4'(DIGITS - 1);

  logic [FRAME-1:0] sr;
  logic [3:0]       cnt;
  logic [5:0]       mem [DIGITS];

  wire [3:0] f_addr = sr[9:6];
  assign accepted = (cnt == FULL) && (f_addr <= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      cnt    <= '0;
      we_o   <= 1'b0;
      addr_o <= '0;
      code_o <= '0;
      ann_o  <= '0;
      for (int i = 0; i < DIGITS; i++) mem[i] <= '0;
    end else begin
      we_o <= 1'b0;
      if (!wr_n) begin
        if (accepted) begin
          mem[f_addr] <= sr[5:0];
          we_o        <= 1'b1;
          addr_o      <= f_addr;
          code_o      <= sr[5:2];
          ann_o       <= sr[1:0];
        end
        sr  <= '0;
        cnt <= '0;
      end else if (shift_en) begin
        sr <= {ser_data, sr[FRAME-1:1]};
        if (cnt != OVER) cnt <= cnt + 4'd1;
      end
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_out
    assign digits_o[6*g +: 6] = mem[g];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!accepted && !we_o && digits_o == '0));

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> !accepted);

  assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && accepted) |=> (we_o && addr_o <= LAST));

  assert_discard_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !accepted) |=> (!we_o && $stable(digits_o)));

  assert_accept_needs_shift_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(accepted) |-> $past(shift_en && wr_n));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o);
endmodule

// File: tb/serial_digit_writer_tb.sv
module serial_digit_writer_tb;
  logic clk = 0, rst = 1, shift_en = 0, ser_data = 0, wr_n = 1;
  logic accepted, we_o;
  logic [3:0] addr_o, code_o;
  logic [1:0] ann_o;
  logic [59:0] digits_o;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [9:0] m_sr;
  int         m_cnt;
  logic [5:0] m_mem [10];
  logic       m_we;
  logic [9:0] m_wfrm;

  always #10 clk = ~clk;

  serial_digit_writer u_dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_data(ser_data), .wr_n(wr_n),
    .accepted(accepted), .we_o(we_o), .addr_o(addr_o), .code_o(code_o),
    .ann_o(ann_o), .digits_o(digits_o));

  function automatic logic exp_acc();
    return (m_cnt == 10) && (m_sr[9:6] <= 4'd9);
  endfunction

  function automatic logic [59:0] exp_digits();
    logic [59:0] v;
    for (int i = 0; i < 10; i++) v[6*i +: 6] = m_mem[i];
    return v;
  endfunction

  function automatic logic [9:0] mk(input int addr, input int code, input int an2, input int an1);
    return {addr[3:0], code[3:0], an2[0], an1[0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = '0; m_cnt = 0; m_we = 0; m_wfrm = '0;
    for (int i = 0; i < 10; i++) m_mem[i] = '0;
  endtask

  task automatic step(input logic s, input logic d, input logic w, input string tag);
    @(negedge clk);
    shift_en = s; ser_data = d; wr_n = !w;
    @(posedge clk);
    m_we = 0;
    if (w) begin
      if (exp_acc()) begin
        m_we = 1; m_wfrm = m_sr;
        m_mem[m_sr[9:6]] = m_sr[5:0];
      end
      m_sr = '0; m_cnt = 0;
    end else if (s) begin
      m_sr = {d, m_sr[9:1]};
      if (m_cnt < 11) m_cnt++;
    end
    @(negedge clk);
    shift_en = 0; wr_n = 1;
    chk(tag, "accepted", 64'(accepted), 64'(exp_acc()));
    chk(tag, "we_o", 64'(we_o), 64'(m_we));
    if (m_we) begin
      chk(tag, "addr_o", 64'(addr_o), 64'(m_wfrm[9:6]));
      chk(tag, "code_o", 64'(code_o), 64'(m_wfrm[5:2]));
      chk(tag, "ann_o", 64'(ann_o), 64'(m_wfrm[1:0]));
    end
    chk(tag, "digits_o", 64'(digits_o), 64'(exp_digits()));
  endtask

  task automatic send(input logic [9:0] f, input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, (i < 10) ? f[i] : 1'($urandom), 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 0;
    chk("R1", "accepted", 64'(accepted), 64'(0));
    chk("R1", "we_o", 64'(we_o), 64'(0));
    chk("R1", "digits_o", 64'(digits_o), 64'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(posedge clk);
    do_reset();

    // R2 / R3 / R6: addr 3, code A, ann2=0, ann1=1
    send(mk(3, 10, 0, 1), 10, "R3");
    chk("R3", "accepted after 10 bits", 64'(accepted), 64'(1));
    step(0, 0, 1, "R6");
    chk("R2", "digit3 field order", 64'(digits_o[23:18]), 64'(6'b101001));

    // R3 boundaries: addr 9 and 0
    send(mk(9, 5, 1, 0), 10, "R3");
    step(0, 0, 1, "R6");
    send(mk(0, 15, 1, 1), 10, "R3");
    step(0, 0, 1, "R6");

    // R4: illegal address, then R7 discard
    send(mk(12, 7, 1, 1), 10, "R4");
    chk("R4", "accepted addr 12", 64'(accepted), 64'(0));
    step(0, 0, 1, "R7");
    send(mk(15, 1, 0, 1), 10, "R4");
    step(0, 0, 1, "R7");

    // R5: 11 and 12 bits
    send(mk(2, 4, 0, 0), 11, "R5");
    chk("R5", "accepted after 11 bits", 64'(accepted), 64'(0));
    step(1, 1, 0, "R5");
    step(0, 0, 1, "R7");

    // R8: partial frame discarded by write
    send(mk(5, 3, 1, 1), 5, "R8");
    step(0, 0, 1, "R8");
    send(mk(6, 9, 0, 1), 10, "R8");
    chk("R8", "fresh frame accepted", 64'(accepted), 64'(1));
    step(0, 0, 1, "R8");

    // R9: write and shift together, on accepted and on partial frames
    send(mk(7, 2, 1, 0), 10, "R9");
    step(1, 1, 1, "R9");
    send(mk(8, 6, 0, 0), 4, "R9");
    step(1, 0, 1, "R9");
    send(mk(1, 12, 1, 1), 10, "R9");
    chk("R9", "frame after collision", 64'(accepted), 64'(1));
    step(0, 0, 1, "R9");

    // random frames of 8..11 bits, random addresses, occasional collisions
    for (int k = 0; k < 300; k++) begin
      int n;
      n = 8 + int'($urandom_range(3));
      send(10'($urandom), n, "R3");
      if ($urandom_range(4) == 0) step(1, 1'($urandom), 1, "R9");
      else step(0, 0, 1, "R6");
    end

    do_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule